// File: doc/BRIEF.md
# Platform System Control Port Block

This block is a bank of byte-wide I/O-port registers for a board controller. A host reaches it through a plain synchronous bus with a select strobe, a write enable, an address and eight data bits. It decodes one isolated port at 0x092 and a window from 0x800 through 0x851. Inside the decoded space, some ports hold control state that drives pins: a soft-reset request, a little-endian mode flag, a disk-activity lamp, a 4-bit system control field and an I/O map type bit. Two ports raise one-cycle lock-toggle pulses for an external NVRAM. The remaining ports return fixed identification and equipment bytes set by parameters.

The bus has no back-pressure. A strobe is accepted in the cycle it is sampled, and the block never stalls. Read data is registered. It appears in the cycle after the strobe and stays the same until the next accepted read. A strobe whose address falls outside the decoded space is ignored. Within the decoded space, an address with no assigned register reads as 0xFF and drops writes.

Top module: `sysctl_ports`

## Requirements
- R1: Reset clears the reset request, the endian flag, the lamp, the control field, the map type bit, both lock pulses and the read data register.
- R2: A write to 0x092 sets the reset request from data bit 0 and the little-endian flag from data bit 1, and both hold until 0x092 is written again.
- R3: A read of 0x092 returns 0x00 whatever was written there.
- R4: A write to 0x808 sets the lamp output to data bit 0, so writing 1 turns it on and writing 0 turns it off.
- R5: A write to 0x81C keeps data bits 3:0 as the control field, which drives the control output. A read of 0x81C returns that field with bits 7:4 zero.
- R6: A write to 0x850 keeps data bit 0 as the map type (0 contiguous, 1 non-contiguous), which drives the map output. A read of 0x850 returns that bit in bit 0 with the other bits zero.
- R7: A write to 0x810 raises lock pulse bit 0, and a write to 0x812 raises lock pulse bit 1. Each pulse is high for exactly the one cycle after the write. The data is ignored and no other state changes.
- R8: Ports 0x800, 0x802 and 0x803 read as their parameter bytes (default 0xEF, 0xAD, 0xE0). Writes to them leave those values unchanged.
- R9: Ports 0x80C, 0x810, 0x818 and 0x823 read as their parameter bytes (default 0x3C, 0x39, 0x00, 0x03).
- R10: A read of an unassigned address inside 0x800..0x851 returns 0xFF. A write there changes no output. 0x801, 0x805, 0x808 (on read), 0x814 and 0x851 are such reads.
- R11: Read data updates only on the clock edge that samples a read strobe, is visible in the following cycle, and holds otherwise. Strobes to addresses outside 0x092 and 0x800..0x851 change neither the read data nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Port address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after a read strobe |
| reset_req | output | 1 | Soft-reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| lamp_on | output | 1 | Disk-activity lamp |
| sys_ctl | output | CTL_W | System control field |
| io_map_sparse | output | 1 | I/O map type, 1 = non-contiguous |
| lock_pulse | output | 2 | NVRAM lock-toggle pulses, bit 0 bank 1, bit 1 bank 2 |

## Verification
The bench checks port 0x810, where a read returns a fixed byte but a write fires a lock pulse. A decoder that treated this port as storage would show a changed read value or a missing pulse. Reads of 0x808, the lamp port, must return 0xFF, and 0x092 must read as zero even after 0xFF is written there. A design that read back its write state would return the written value on these ports. Writes of 0xA5 and 0x3F to the control port catch a field that keeps or returns its upper bits. A write to the unassigned port 0x805 and a write to the out-of-range port 0x91C catch decoding that leaks into real registers. A read-timing probe taken just before the sampling edge, and reads outside the decoded space, catch read data that changes too early or on ignored strobes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    P_NONE,    // decoded space, unassigned
    P_CTL92,
    P_CPUID,
    P_FEAT,
    P_STAT,
    P_LAMP,
    P_EQUIP,
    P_LOCK1,
    P_LOCK2,
    P_KEY,
    P_SYSCTL,
    P_CACHE,
    P_MAP,
    P_OUT      // outside decoded space
  } port_e;

  localparam int unsigned A_CTL92  = 'h092;
  localparam int unsigned A_WIN_LO = 'h800;
  localparam int unsigned A_WIN_HI = 'h851;
  localparam int unsigned A_CPUID  = 'h800;
  localparam int unsigned A_FEAT   = 'h802;
  localparam int unsigned A_STAT   = 'h803;
  localparam int unsigned A_LAMP   = 'h808;
  localparam int unsigned A_EQUIP  = 'h80C;
  localparam int unsigned A_LOCK1  = 'h810;
  localparam int unsigned A_LOCK2  = 'h812;
  localparam int unsigned A_KEY    = 'h818;
  localparam int unsigned A_SYSCTL = 'h81C;
  localparam int unsigned A_CACHE  = 'h823;
  localparam int unsigned A_MAP    = 'h850;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output port_e             port
);

  localparam int unsigned AW = ADDR_W;

  always_comb begin
    port = P_OUT;
    if (addr == AW'(A_CTL92)) begin
      port = P_CTL92;
    end else if (addr >= AW'(A_WIN_LO) && addr <= AW'(A_WIN_HI)) begin
      unique case (addr)
        AW'(A_CPUID):  port = P_CPUID;
        AW'(A_FEAT):   port = P_FEAT;
        AW'(A_STAT):   port = P_STAT;
        AW'(A_LAMP):   port = P_LAMP;
        AW'(A_EQUIP):  port = P_EQUIP;
        AW'(A_LOCK1):  port = P_LOCK1;
        AW'(A_LOCK2):  port = P_LOCK2;
        AW'(A_KEY):    port = P_KEY;
        AW'(A_SYSCTL): port = P_SYSCTL;
        AW'(A_CACHE):  port = P_CACHE;
        AW'(A_MAP):    port = P_MAP;
        default:       port = P_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int CTL_W  = 4,
  parameter int NBANK  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  port_e             port,
  input  logic [DATA_W-1:0] wdata,
  output logic              reset_req,
  output logic              le_mode,
  output logic              lamp_on,
  output logic [CTL_W-1:0]  sys_ctl,
  output logic              io_map_sparse,
  output logic [NBANK-1:0]  lock_pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_req     <= 1'b0;
      le_mode       <= 1'b0;
      lamp_on       <= 1'b0;
      sys_ctl       <= '0;
      io_map_sparse <= 1'b0;
    end else if (wr_en) begin
      case (port)
        P_CTL92: begin
          reset_req <= wdata[0];
          le_mode   <= wdata[1];
        end
        P_LAMP:   lamp_on       <= wdata[0];
        P_SYSCTL: sys_ctl       <= wdata[CTL_W-1:0];
        P_MAP:    io_map_sparse <= wdata[0];
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_lock
    localparam port_e BANK_PORT = (b == 0) ? P_LOCK1 : P_LOCK2;
    always_ff @(posedge clk) begin
      if (!rst_n) lock_pulse[b] <= 1'b0;
      else        lock_pulse[b] <= wr_en && (port == BANK_PORT);
    end
  end

  // R2
  reset_req_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req != $past(reset_req) || le_mode != $past(le_mode))
      |-> $past(wr_en && port == P_CTL92));

  // R5
  sys_ctl_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_ctl != $past(sys_ctl)) |-> $past(wr_en && port == P_SYSCTL));

  // R7
  lock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse[0] |-> $past(wr_en && port == P_LOCK1));

  // R7
  lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_pulse));

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int               CTL_W    = 4,
  parameter logic [DATA_W-1:0] B_CPUID = 8'hEF,
  parameter logic [DATA_W-1:0] B_FEAT  = 8'hAD,
  parameter logic [DATA_W-1:0] B_STAT  = 8'hE0,
  parameter logic [DATA_W-1:0] B_EQUIP = 8'h3C,
  parameter logic [DATA_W-1:0] B_EXTF  = 8'h39,
  parameter logic [DATA_W-1:0] B_KEY   = 8'h00,
  parameter logic [DATA_W-1:0] B_CACHE = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  port_e             port,
  input  logic [CTL_W-1:0]  sys_ctl,
  input  logic              io_map_sparse,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - CTL_W;

  logic [DATA_W-1:0] sel_byte;

  always_comb begin
    unique case (port)
      P_CTL92:  sel_byte = '0;
      P_CPUID:  sel_byte = B_CPUID;
      P_FEAT:   sel_byte = B_FEAT;
      P_STAT:   sel_byte = B_STAT;
      P_EQUIP:  sel_byte = B_EQUIP;
      P_LOCK1:  sel_byte = B_EXTF;
      P_KEY:    sel_byte = B_KEY;
      P_CACHE:  sel_byte = B_CACHE;
      P_SYSCTL: sel_byte = {{PAD_W{1'b0}}, sys_ctl};
      P_MAP:    sel_byte = {{(DATA_W-1){1'b0}}, io_map_sparse};
      default:  sel_byte = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel_byte;
  end

  // R10
  unassigned_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && port == P_NONE) |=> (rdata == 8'hFF));

  // R3
  ctl92_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && port == P_CTL92) |=> (rdata == 8'h00));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/sysctl_ports.sv
module sysctl_ports
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          CTL_W   = 4,
  parameter logic [7:0]  B_CPUID = 8'hEF,
  parameter logic [7:0]  B_FEAT  = 8'hAD,
  parameter logic [7:0]  B_STAT  = 8'hE0,
  parameter logic [7:0]  B_EQUIP = 8'h3C,
  parameter logic [7:0]  B_EXTF  = 8'h39,
  parameter logic [7:0]  B_KEY   = 8'h00,
  parameter logic [7:0]  B_CACHE = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              reset_req,
  output logic              le_mode,
  output logic              lamp_on,
  output logic [CTL_W-1:0]  sys_ctl,
  output logic              io_map_sparse,
  output logic [1:0]        lock_pulse
);

  localparam int NBANK = 2;

  port_e port;
  logic  hit, wr_en, rd_en;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .port (port)
  );

  assign hit   = bus_sel && (port != P_OUT);
  assign wr_en = hit && bus_wr;
  assign rd_en = hit && !bus_wr;

  sysctl_regs #(.CTL_W(CTL_W), .NBANK(NBANK)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .port          (port),
    .wdata         (bus_wdata),
    .reset_req     (reset_req),
    .le_mode       (le_mode),
    .lamp_on       (lamp_on),
    .sys_ctl       (sys_ctl),
    .io_map_sparse (io_map_sparse),
    .lock_pulse    (lock_pulse)
  );

  sysctl_rdmux #(
    .CTL_W(CTL_W), .B_CPUID(B_CPUID), .B_FEAT(B_FEAT), .B_STAT(B_STAT),
    .B_EQUIP(B_EQUIP), .B_EXTF(B_EXTF), .B_KEY(B_KEY), .B_CACHE(B_CACHE)
  ) u_rd (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (rd_en),
    .port          (port),
    .sys_ctl       (sys_ctl),
    .io_map_sparse (io_map_sparse),
    .rdata         (bus_rdata)
  );

  // R6
  map_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_map_sparse != $past(io_map_sparse))
      |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'('h850)));

endmodule

// File: tb/sim_sysctl_ports.sv
module sim_sysctl_ports;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        reset_req, le_mode, lamp_on, io_map_sparse;
  logic [3:0]  sys_ctl;
  logic [1:0]  lock_pulse;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_ports u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reset_req(reset_req), .le_mode(le_mode), .lamp_on(lamp_on),
    .sys_ctl(sys_ctl), .io_map_sparse(io_map_sparse), .lock_pulse(lock_pulse)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0800, 8'h00, 8'hEF, 4'd8},   // R8
    '{1'b0, 16'h0802, 8'h00, 8'hAD, 4'd8},
    '{1'b0, 16'h0803, 8'h00, 8'hE0, 4'd8},
    '{1'b0, 16'h080C, 8'h00, 8'h3C, 4'd9},   // R9
    '{1'b0, 16'h0810, 8'h00, 8'h39, 4'd9},
    '{1'b0, 16'h0818, 8'h00, 8'h00, 4'd9},
    '{1'b0, 16'h0823, 8'h00, 8'h03, 4'd9},
    '{1'b0, 16'h0092, 8'h00, 8'h00, 4'd3},   // R3
    '{1'b0, 16'h081C, 8'h00, 8'h00, 4'd5},   // R5
    '{1'b0, 16'h0850, 8'h00, 8'h00, 4'd6},   // R6
    '{1'b0, 16'h0801, 8'h00, 8'hFF, 4'd10},  // R10
    '{1'b0, 16'h0808, 8'h00, 8'hFF, 4'd10},
    '{1'b0, 16'h0814, 8'h00, 8'hFF, 4'd10},
    '{1'b0, 16'h0851, 8'h00, 8'hFF, 4'd10},
    '{1'b1, 16'h0800, 8'h00, 8'h00, 4'd8},
    '{1'b0, 16'h0800, 8'h00, 8'hEF, 4'd8},
    '{1'b1, 16'h0803, 8'hFF, 8'h00, 4'd8},
    '{1'b0, 16'h0803, 8'h00, 8'hE0, 4'd8},
    '{1'b1, 16'h081C, 8'hA5, 8'h00, 4'd5},
    '{1'b0, 16'h081C, 8'h00, 8'h05, 4'd5},
    '{1'b1, 16'h0850, 8'hFE, 8'h00, 4'd6},
    '{1'b0, 16'h0850, 8'h00, 8'h00, 4'd6},
    '{1'b1, 16'h0850, 8'h01, 8'h00, 4'd6},
    '{1'b0, 16'h0850, 8'h00, 8'h01, 4'd6},
    '{1'b1, 16'h0092, 8'hFF, 8'h00, 4'd3},
    '{1'b0, 16'h0092, 8'h00, 8'h00, 4'd3},
    '{1'b1, 16'h081C, 8'h3F, 8'h00, 4'd5},
    '{1'b0, 16'h081C, 8'h00, 8'h0F, 4'd5}
  };

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      fails = fails + 1;
      $display("FAIL R11 watchdog: actual cycles=%0d expected below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge sample, return at the next falling edge.
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_reset_state(input string tag);
    chk({tag, " reset_req"}, int'(reset_req), 0);
    chk({tag, " le_mode"}, int'(le_mode), 0);
    chk({tag, " lamp_on"}, int'(lamp_on), 0);
    chk({tag, " sys_ctl"}, int'(sys_ctl), 0);
    chk({tag, " io_map_sparse"}, int'(io_map_sparse), 0);
    chk({tag, " lock_pulse"}, int'(lock_pulse), 0);
    chk({tag, " bus_rdata"}, int'(bus_rdata), 0);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_reset_state("R1 initial");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        bus_write(VECS[i].addr, VECS[i].data);
      end else begin
        bus_read(VECS[i].addr, rd);
        chk($sformatf("R%0d table vector %0d addr 0x%0h", VECS[i].req, i, VECS[i].addr),
            int'(rd), int'(VECS[i].exp));
      end
    end

    // R1: mid-run reset after table left state set
    apply_reset();
    chk_reset_state("R1 mid-run");

    // R2: control port bits and hold
    bus_write(16'h0092, 8'h01);
    chk("R2 reset_req after 0x01", int'(reset_req), 1);
    chk("R2 le_mode after 0x01", int'(le_mode), 0);
    bus_write(16'h0092, 8'h02);
    chk("R2 reset_req after 0x02", int'(reset_req), 0);
    chk("R2 le_mode after 0x02", int'(le_mode), 1);
    bus_write(16'h0808, 8'h01);
    repeat (3) @(negedge clk);
    chk("R2 le_mode hold", int'(le_mode), 1);
    chk("R2 reset_req hold", int'(reset_req), 0);
    bus_write(16'h0092, 8'h00);
    chk("R2 le_mode cleared", int'(le_mode), 0);

    // R4: lamp on and off
    bus_write(16'h0808, 8'h03);
    chk("R4 lamp on", int'(lamp_on), 1);
    bus_write(16'h0808, 8'hFE);
    chk("R4 lamp off", int'(lamp_on), 0);

    // R5 / R6 outputs
    bus_write(16'h081C, 8'h69);
    chk("R5 sys_ctl output", int'(sys_ctl), 9);
    bus_write(16'h0850, 8'h03);
    chk("R6 map output", int'(io_map_sparse), 1);

    // R7: lock pulses
    bus_write(16'h0810, 8'h00);
    chk("R7 bank1 pulse", int'(lock_pulse), 1);
    @(negedge clk);
    chk("R7 bank1 pulse ends", int'(lock_pulse), 0);
    bus_write(16'h0812, 8'hFF);
    chk("R7 bank2 pulse", int'(lock_pulse), 2);
    @(negedge clk);
    chk("R7 bank2 pulse ends", int'(lock_pulse), 0);
    chk("R7 sys_ctl untouched", int'(sys_ctl), 9);
    chk("R7 lamp untouched", int'(lamp_on), 0);
    chk("R7 map untouched", int'(io_map_sparse), 1);
    bus_read(16'h0810, rd);
    chk("R7 read of 0x810 unchanged", int'(rd), 8'h39);

    // R10: unassigned write dropped
    bus_write(16'h0805, 8'hFF);
    chk("R10 sys_ctl after 0x805 write", int'(sys_ctl), 9);
    chk("R10 map after 0x805 write", int'(io_map_sparse), 1);
    chk("R10 lamp after 0x805 write", int'(lamp_on), 0);
    chk("R10 reset_req after 0x805 write", int'(reset_req), 0);
    chk("R10 lock after 0x805 write", int'(lock_pulse), 0);
    bus_read(16'h0805, rd);
    chk("R10 read 0x805", int'(rd), 8'hFF);

    // R11: read timing, hold, out-of-range strobes
    bus_read(16'h0823, rd);
    chk("R11 read 0x823", int'(rd), 8'h03);
    @(negedge clk);
    chk("R11 rdata held while idle", int'(bus_rdata), 8'h03);
    bus_read(16'h0900, rd);
    chk("R11 out-of-range read ignored", int'(rd), 8'h03);
    bus_read(16'h0093, rd);
    chk("R11 0x093 read ignored", int'(rd), 8'h03);
    bus_write(16'h091C, 8'h00);
    chk("R11 out-of-range write ignored", int'(sys_ctl), 9);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 16'h0800;
    #(CLK_PERIOD/4);
    chk("R11 rdata before sampling edge", int'(bus_rdata), 8'h03);
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R11 rdata after sampling edge", int'(bus_rdata), 8'hEF);

    finish_run();
  end

endmodule